// File: doc/BRIEF.md
# Legacy Window Shadow Router

This block sits on the path of every memory access that falls into the top of the first megabyte, from 0xA0000 up to 0xFFFFF. For each access it returns a routing decision. The access can go to main memory with reads and writes, to main memory as read-only, or out to the I/O bus. It also returns a flag that marks a write as one to drop. A byte-wide configuration write port loads the attribute bytes and the system-management control byte that drive the decode. A separate input tells the block whether the processor is in system-management mode.

The window above 0xC0000 has thirteen shadow regions. Twelve of them are 16 KB segments starting at 0xC0000, and the last is a single 64 KB region at 0xF0000. Each region has a 2-bit attribute packed into one nibble of an attribute byte. The 128 KB video hole at 0xA0000 has no attribute of its own. The control byte opens it to memory, either unconditionally or only while system-management mode is active. Every address below 0xA0000 goes to main memory.

The result is registered. A strobe-qualified access produces its decision on the next clock edge.

Top module: `lgw_route`

## Requirements
- R1: `dec_valid` is high in the cycle after each cycle in which `acc_valid` is high, and low after every cycle in which `acc_valid` is low; `dec_route` and `dec_wr_block` are meaningful only while `dec_valid` is high.
- R2: An access with an address below 0xA0000 always gives route code 0 (memory read/write) and no write block.
- R3: An access in 0xF0000–0xFFFFF uses the attribute held in bits [5:4] of the configuration byte at offset 0x59.
- R4: Segment i (i = 0..11) covers 0xC0000 + i·0x4000 for 16 KB and uses the configuration byte at offset 0x5A + (i >> 1): bits [1:0] for even i, bits [5:4] for odd i.
- R5: Attribute 3 gives route code 0 (memory read/write), attribute 1 gives route code 1 (memory read-only), and attributes 0 and 2 give route code 2 (I/O bus), for reads and writes alike.
- R6: An access in 0xA0000–0xBFFFF gives route code 0 when bit 6 of the control byte at offset 0x72 is set, or when `smm_active` is high and bit 3 of that byte is set; otherwise it gives route code 2.
- R7: After reset, all attribute bytes are 0x00 and the control byte is 0x02, so every access in 0xA0000–0xFFFFF goes to route code 2, and `dec_valid` is low.
- R8: `dec_wr_block` is high only for a write access that decodes to route code 1.
- R9: A configuration write to any offset other than 0x59–0x5F and 0x72 has no effect on the decode.
- R10: A configuration write applies to an access presented in the next cycle. The `smm_active` value presented together with an access is the one used for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| smm_active | input | 1 | System-management mode is active |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 20 | Access byte address |
| acc_write | input | 1 | Access is a write |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_route | output | 2 | 0 memory read/write, 1 memory read-only, 2 I/O bus |
| dec_wr_block | output | 1 | Write must be suppressed |

## Verification
The bench programs every one of the thirteen regions with each of the four attribute values. It always loads the neighbouring nibble with a different value. A design that swapped nibbles, selected the wrong byte for odd segments or miscounted the segment index would then route a region with its neighbour's attribute. Each setting is probed at the first and last address of its region, both read and write. An off-by-one in the region boundaries would therefore decode a boundary address with the wrong attribute, and a design that confused attribute 1 with 2 would either block writes that belong on the bus or pass writes to read-only memory. The video hole is tried with every combination of the open bit, the enable bit and the mode input. This catches an enable that ignores the mode input or an open bit that depends on it. Writes to offsets just outside the programmed range must leave the decode untouched.

// File: rtl/lgw_pkg.sv
package lgw_pkg;

  typedef enum logic [1:0] {
    RT_MEM_RW = 2'd0,
    RT_MEM_RO = 2'd1,
    RT_IO_BUS = 2'd2
  } route_e;

  // Two-bit region attribute to route: 3 -> RW, 1 -> RO, 0/2 -> bus.
  function automatic route_e attr_to_route(input logic [1:0] attr);
    route_e r;
    case (attr)
      2'd3:    r = RT_MEM_RW;
      2'd1:    r = RT_MEM_RO;
      default: r = RT_IO_BUS;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lgw_cfg_regs.sv
module lgw_cfg_regs #(
  parameter int          CFG_AW     = 8,
  parameter int          DW         = 8,
  parameter int          ATTR_BYTES = 7,
  parameter logic [7:0]  ATTR_BASE  = 8'h59,
  parameter logic [7:0]  SMC_OFF    = 8'h72,
  parameter logic [7:0]  SMC_RST    = 8'h02
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [DW-1:0]                    cfg_wdata,
  output logic [ATTR_BYTES-1:0][DW-1:0]    attr_bytes,
  output logic [DW-1:0]                    smc_q
);

  localparam logic [CFG_AW-1:0] BASE_A = CFG_AW'(ATTR_BASE);
  localparam logic [CFG_AW-1:0] SMC_A  = CFG_AW'(SMC_OFF);

  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
    localparam logic [CFG_AW-1:0] MY_A = BASE_A + CFG_AW'(b);
    always_ff @(posedge clk) begin
      if (rst) begin
        attr_bytes[b] <= '0;
      end else if (cfg_we && cfg_addr == MY_A) begin
        attr_bytes[b] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smc_q <= DW'(SMC_RST);
    end else if (cfg_we && cfg_addr == SMC_A) begin
      smc_q <= cfg_wdata;
    end
  end

endmodule

// File: rtl/lgw_attr_sel.sv
module lgw_attr_sel #(
  parameter int ADDR_W     = 20,
  parameter int DW         = 8,
  parameter int ATTR_BYTES = 7,
  parameter int SEG_COUNT  = 12,
  parameter int SEG_LOG2   = 14,
  parameter int TOP_NIB    = 1
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [ATTR_BYTES-1:0][DW-1:0]  attr_bytes,
  output logic                           in_shadow,
  output logic [1:0]                     attr
);

  localparam int SEG_W    = 4;
  localparam int NIB_W    = 4;
  localparam int BLK_LOG2 = SEG_LOG2 + 2;

  logic [SEG_COUNT-1:0][1:0] seg_attr;
  logic [SEG_W-1:0]          seg_idx;
  logic                      in_top;

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
    assign seg_attr[i] = attr_bytes[1 + i/2][(i%2)*NIB_W +: 2];
  end

  // Shadow window is the upper quarter of the address space.
  assign in_shadow = (addr[ADDR_W-1 -: 2] == 2'b11);
  assign in_top    = (addr[BLK_LOG2 +: 2] == 2'b11);
  assign seg_idx   = addr[SEG_LOG2 +: SEG_W];

  always_comb begin
    if (in_top) begin
      attr = attr_bytes[0][TOP_NIB*NIB_W +: 2];
    end else if (int'(seg_idx) < SEG_COUNT) begin
      attr = seg_attr[seg_idx];
    end else begin
      attr = 2'd0;
    end
  end

endmodule

// File: rtl/lgw_video_gate.sv
module lgw_video_gate #(
  parameter int ADDR_W   = 20,
  parameter int DW       = 8,
  parameter int OPEN_BIT = 6,
  parameter int EN_BIT   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     smc,
  input  logic              smm,
  output logic              in_video,
  output logic              to_mem
);

  // 0xA0000-0xBFFFF: top three address bits equal 3'b101.
  assign in_video = (addr[ADDR_W-1 -: 3] == 3'b101);
  assign to_mem   = smc[OPEN_BIT] | (smm & smc[EN_BIT]);

endmodule

// File: rtl/lgw_route.sv
module lgw_route #(
  parameter int ADDR_W     = 20,
  parameter int CFG_AW     = 8,
  parameter int DW         = 8,
  parameter int ATTR_BYTES = 7,
  parameter int SEG_COUNT  = 12,
  parameter int SEG_LOG2   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              smm_active,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              dec_valid,
  output logic [1:0]        dec_route,
  output logic              dec_wr_block
);
  import lgw_pkg::*;

  logic [ATTR_BYTES-1:0][DW-1:0] attr_bytes;
  logic [DW-1:0]                 smc_q;
  logic                          in_shadow, in_video, vid_mem;
  logic [1:0]                    attr;
  route_e                        nxt_route;

  lgw_cfg_regs #(
    .CFG_AW(CFG_AW), .DW(DW), .ATTR_BYTES(ATTR_BYTES)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .attr_bytes(attr_bytes), .smc_q(smc_q)
  );

  lgw_attr_sel #(
    .ADDR_W(ADDR_W), .DW(DW), .ATTR_BYTES(ATTR_BYTES),
    .SEG_COUNT(SEG_COUNT), .SEG_LOG2(SEG_LOG2)
  ) u_sel (
    .addr(acc_addr), .attr_bytes(attr_bytes),
    .in_shadow(in_shadow), .attr(attr)
  );

  lgw_video_gate #(
    .ADDR_W(ADDR_W), .DW(DW)
  ) u_vid (
    .addr(acc_addr), .smc(smc_q), .smm(smm_active),
    .in_video(in_video), .to_mem(vid_mem)
  );

  always_comb begin
    if (in_shadow) begin
      nxt_route = attr_to_route(attr);
    end else if (in_video) begin
      nxt_route = vid_mem ? RT_MEM_RW : RT_IO_BUS;
    end else begin
      nxt_route = RT_MEM_RW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid    <= 1'b0;
      dec_route    <= RT_IO_BUS;
      dec_wr_block <= 1'b0;
    end else begin
      dec_valid <= acc_valid;
      if (acc_valid) begin
        dec_route    <= nxt_route;
        dec_wr_block <= acc_write && (nxt_route == RT_MEM_RO);
      end
    end
  end

endmodule

// File: rtl/lgw_route_chk.sv
module lgw_route_chk #(
  parameter int ADDR_W = 20,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              smm_active,
  input logic [DW-1:0]     smc_q,
  input logic              dec_valid,
  input logic [1:0]        dec_route,
  input logic              dec_wr_block
);
  import lgw_pkg::*;

  logic low_mem, vid;
  assign low_mem = acc_addr < ADDR_W'(20'hA0000);
  assign vid     = acc_addr[ADDR_W-1 -: 3] == 3'b101;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> dec_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !dec_valid); // R1
  AST_LOW_TO_RAM: assert property (@(posedge clk) disable iff (rst)
    acc_valid && low_mem |=> dec_route == RT_MEM_RW && !dec_wr_block); // R2
  AST_VIDEO_OPEN: assert property (@(posedge clk) disable iff (rst)
    acc_valid && vid && smc_q[6] |=> dec_route == RT_MEM_RW); // R6
  AST_VIDEO_SHUT: assert property (@(posedge clk) disable iff (rst)
    acc_valid && vid && !smc_q[6] && !(smm_active && smc_q[3])
      |=> dec_route == RT_IO_BUS); // R6
  AST_BLOCK_ONLY_RO: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_wr_block |-> dec_route == RT_MEM_RO); // R8
  AST_READ_NOT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_write |=> !dec_wr_block); // R8

endmodule

bind lgw_route lgw_route_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_write(acc_write), .smm_active(smm_active), .smc_q(smc_q),
  .dec_valid(dec_valid), .dec_route(dec_route), .dec_wr_block(dec_wr_block)
);

// File: tb/lgw_route_bench.sv
`timescale 1ns/1ps
module lgw_route_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        smm_active = 1'b0;
  logic        acc_valid = 1'b0;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        dec_valid;
  logic [1:0]  dec_route;
  logic        dec_wr_block;

  always #4 clk = ~clk;

  lgw_route u_lgw_route (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .dec_valid(dec_valid),
    .dec_route(dec_route), .dec_wr_block(dec_wr_block)
  );

  typedef struct {
    logic [1:0] route;
    logic       blk;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 1'b0;
  logic [7:0] sh_attr [7];
  logic [7:0] sh_smc;

  function automatic logic [1:0] map_attr(input logic [1:0] a);
    return (a == 2'd3) ? 2'd0 : (a == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [1:0] model(input logic [19:0] a, input logic smm);
    int seg;
    if (a < 20'hA0000) return 2'd0;
    if (a < 20'hC0000) return (sh_smc[6] || (smm && sh_smc[3])) ? 2'd0 : 2'd2;
    if (a >= 20'hF0000) return map_attr(sh_attr[0][5:4]);
    seg = int'((a - 20'hC0000) >> 14);
    return map_attr(2'((sh_attr[1 + seg/2] >> ((seg%2)*4)) & 8'h3));
  endfunction

  task automatic cfg_wr(input logic [7:0] off, input logic [7:0] val);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = val;
    if (off >= 8'h59 && off <= 8'h5F) sh_attr[off - 8'h59] = val;
    if (off == 8'h72) sh_smc = val;
  endtask

  task automatic access(input logic [19:0] a, input logic wr, input logic smm,
                        input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = 1'b0;
    acc_valid = 1'b1; acc_addr = a; acc_write = wr; smm_active = smm;
    e.route = model(a, smm);
    e.blk   = wr && (e.route == 2'd1);
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cfg_we = 1'b0; acc_valid = 1'b0;
    end
  endtask

  // Monitor: compare each decision against the oldest expected item.
  always begin
    @(posedge clk); #1;
    if (!rst && dec_valid) begin
      n_checks++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected dec_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (dec_route !== e.route || dec_wr_block !== e.blk) begin
          n_fail++;
          $display("FAIL %s addr route/blk: actual %0d/%0d expected %0d/%0d",
                   e.tag, dec_route, dec_wr_block, e.route, e.blk);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 7; i++) sh_attr[i] = 8'h00;
    sh_smc = 8'h02;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    n_checks++;
    if (dec_valid !== 1'b0) begin
      n_fail++; $display("FAIL R7 dec_valid after reset: actual %b expected 0", dec_valid);
    end

    // R7: reset state routes the whole window to the bus.
    access(20'hA0000, 1'b0, 1'b0, "R7");
    access(20'hC0000, 1'b1, 1'b0, "R7");
    access(20'hE7FFF, 1'b0, 1'b0, "R7");
    access(20'hFFFFF, 1'b1, 1'b0, "R7");
    idle(1);
    @(posedge clk); #1;
    n_checks++;
    if (dec_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1 dec_valid while idle: actual %b expected 0", dec_valid);
    end

    // R2: memory below the window.
    access(20'h00000, 1'b1, 1'b0, "R2");
    access(20'h9FFFF, 1'b1, 1'b1, "R2");

    // R3 R4 R5 R8 R10: sweep every region and attribute.
    for (int r = 0; r < 13; r++) begin
      for (int a = 0; a < 4; a++) begin
        logic [7:0]  off, val;
        logic [19:0] lo, hi;
        string       tg;
        if (r == 12) begin
          off = 8'h59; val = 8'((a << 4) | (3 - a));
          lo = 20'hF0000; hi = 20'hFFFFF; tg = "R3 R5 R8 R10";
        end else begin
          off = 8'h5A + 8'(r / 2);
          val = ((r % 2) == 1) ? 8'((a << 4) | (3 - a)) : 8'(((3 - a) << 4) | a);
          lo = 20'hC0000 + 20'(r * 32'h4000); hi = lo + 20'h3FFF;
          tg = "R4 R5 R8 R10";
        end
        cfg_wr(off, val);
        access(lo, 1'b0, 1'b0, tg);
        access(lo, 1'b1, 1'b0, tg);
        access(hi, 1'b1, 1'b1, tg);
        access(hi, 1'b0, 1'b1, tg);
      end
    end

    // R6 R10: video hole with every control and mode combination.
    for (int c = 0; c < 4; c++) begin
      logic [7:0] sv;
      sv = 8'h02 | ((c & 1) != 0 ? 8'h40 : 8'h00) | ((c & 2) != 0 ? 8'h08 : 8'h00);
      cfg_wr(8'h72, sv);
      for (int m = 0; m < 2; m++) begin
        access(20'hA0000, 1'b1, 1'(m), "R6 R10");
        access(20'hBFFFF, 1'b0, 1'(m), "R6 R10");
      end
    end

    // R9: writes to neighbouring offsets are ignored.
    cfg_wr(8'h5A, 8'h13);
    cfg_wr(8'h72, 8'h02);
    cfg_wr(8'h58, 8'hFF);
    cfg_wr(8'h60, 8'h00);
    cfg_wr(8'h71, 8'h40);
    cfg_wr(8'h73, 8'h48);
    access(20'hC0000, 1'b1, 1'b0, "R9");
    access(20'hC4000, 1'b1, 1'b0, "R9");
    access(20'hA8000, 1'b0, 1'b1, "R9");

    idle(3);
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++; $display("FAIL R1 missing decisions: actual %0d expected 0", sb.size());
    end
    finish_run();
  end

endmodule